// File: doc/BRIEF.md
# Collision, Jabber and Heartbeat Indicator Controller

This block drives the collision-presence indicator of a coaxial Ethernet transceiver. The indicator is a differential pair that carries a gated 10 MHz square wave whenever any of three conditions holds. The first is a collision-threshold flag from an analog comparator outside this block. The second is a jabber lockout, which the block sets when transmit activity runs too long. The third is a short heartbeat burst that follows each end of transmission. When no condition holds, both legs of the pair sit low, giving zero differential.

The jabber lockout also raises a transmit-disable line. It stays latched until the transmit input has been quiet for a long, uninterrupted unjab period. Any activity inside that period starts the period over. The heartbeat burst can be switched off with an enable input. Each new end of transmission restarts a pending heartbeat delay.

All timers count cycles of a 100 MHz sampling clock. Their lengths are parameters, so a simulation can shorten them. The 10 MHz tone comes from dividing the sampling clock by `DIV_RATIO`.

Top module: `coll_ind_ctrl`

## Requirements
- R1: While `coll_thresh_i` is sampled high on a clock edge, the pair `coll_p_o`/`coll_n_o` is active (one leg high) from the next cycle on.
- R2: `tx_active_i` sampled high on `JAB_TICKS` consecutive edges sets the jabber lock, and `tx_disable_o` goes high after the last of those edges. A shorter run of activity, broken by even one quiet cycle, does not set the lock.
- R3: While the jabber lock is set, the pair is active.
- R4: The lock clears after `UNJAB_TICKS` consecutive quiet edges. Clearing drops `tx_disable_o` and removes the indicator. It also resets the activity timer, so a fresh lock again needs `JAB_TICKS` active edges.
- R5: Any edge with `tx_active_i` high while locked restarts the unjab count from zero.
- R6: With `hb_en_i` high, a `tx_end_i` pulse sampled on edge E puts the pair active for exactly `HB_LEN` cycles, starting `HB_DLY + 1` cycles after E.
- R7: A new `tx_end_i` pulse arriving while a heartbeat is pending restarts the delay, measured from the new pulse.
- R8: With `hb_en_i` low, `tx_end_i` produces no burst. Lowering `hb_en_i` also cancels a pending heartbeat.
- R9: With no source active the pair is 0/0. When active, `coll_p_o` is high for `DIV_RATIO/2` cycles, then `coll_n_o` is high for `DIV_RATIO/2` cycles, and so on. The pattern starts with `coll_p_o` high on the first active cycle, and the two legs are never high together.
- R10: After reset, `coll_p_o`, `coll_n_o` and `tx_disable_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (100 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| coll_thresh_i | input | 1 | Collision-threshold flag from the comparator |
| tx_active_i | input | 1 | Transmit data is currently valid |
| tx_end_i | input | 1 | One-cycle pulse at the end of a transmission |
| hb_en_i | input | 1 | Heartbeat enable |
| coll_p_o | output | 1 | Indicator, positive leg |
| coll_n_o | output | 1 | Indicator, negative leg |
| tx_disable_o | output | 1 | High while the jabber lock holds the transmitter off |

## Verification
The bench hits the exact cycle on which the jabber lock sets, `JAB_TICKS`, and the cycle on which it clears, `UNJAB_TICKS`, probing one cycle before each boundary as well. An off-by-one counter would move either edge by a cycle and be caught.

It inserts a single active cycle inside the unjab period. A design that only paused the count, instead of restarting it, would release the lock early. It checks that a lock cleared by unjab needs a full fresh activity run; a design that kept the old activity count would re-lock at once.

For the heartbeat, the bench measures burst start and length. It sends a second end-of-transmission pulse during the delay, which a design that ignored the restart would answer early. It drops the enable while a heartbeat is pending, which a non-cancelling design would still answer. It also counts tone phases, which exposes a divider with the wrong duty cycle or a first phase that is chopped.

// File: rtl/coll_ind_pkg.sv
package coll_ind_pkg;
  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_e;
endpackage

// File: rtl/tone_div.sv
module tone_div #(
  parameter int DIV_RATIO = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tone_hi_o
);
  localparam int CW   = (DIV_RATIO > 1) ? $clog2(DIV_RATIO) : 1;
  localparam int HALF = DIV_RATIO / 2;
  localparam logic [CW-1:0] LAST  = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] HALFV = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!run_i)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tone_hi_o = (cnt_q < HALFV);

  assert_div_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_div_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/jab_guard.sv
module jab_guard #(
  parameter int JAB_TICKS   = 2_000_000,
  parameter int UNJAB_TICKS = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_act_i,
  output logic lock_o
);
  localparam int JW = $clog2(JAB_TICKS + 1);
  localparam int UW = $clog2(UNJAB_TICKS + 1);
  localparam logic [JW-1:0] JAB_LAST   = JW'(JAB_TICKS - 1);
  localparam logic [UW-1:0] UNJAB_LAST = UW'(UNJAB_TICKS - 1);

  logic          lock_q, lock_d;
  logic [JW-1:0] run_q, run_d;
  logic [UW-1:0] quiet_q, quiet_d;

  always_comb begin
    lock_d  = lock_q;
    run_d   = '0;
    quiet_d = '0;
    if (!lock_q) begin
      if (tx_act_i) begin
        if (run_q == JAB_LAST) lock_d = 1'b1;
        else                   run_d  = run_q + 1'b1;
      end
    end else begin
      if (!tx_act_i) begin
        if (quiet_q == UNJAB_LAST) lock_d  = 1'b0;
        else                       quiet_d = quiet_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q  <= 1'b0;
      run_q   <= '0;
      quiet_q <= '0;
    end else begin
      lock_q  <= lock_d;
      run_q   <= run_d;
      quiet_q <= quiet_d;
    end
  end

  assign lock_o = lock_q;

  assert_quiet_no_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && !tx_act_i) |=> !lock_q);
  assert_active_holds_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && tx_act_i) |=> lock_q);
  assert_unlock_after_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lock_q) |-> $past(!tx_act_i));
endmodule

// File: rtl/hb_timer.sv
module hb_timer
  import coll_ind_pkg::*;
#(
  parameter int HB_DLY = 100,
  parameter int HB_LEN = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic end_i,
  output logic burst_o
);
  localparam int MAXT = (HB_DLY > HB_LEN) ? HB_DLY : HB_LEN;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] DLY_LAST = CW'(HB_DLY - 1);
  localparam logic [CW-1:0] LEN_LAST = CW'(HB_LEN - 1);

  hb_state_e     st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q + 1'b1;
    if (!en_i) begin
      st_d  = HB_IDLE;
      cnt_d = '0;
    end else if (end_i) begin
      st_d  = HB_WAIT;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        HB_WAIT: if (cnt_q == DLY_LAST) begin
          st_d  = HB_BURST;
          cnt_d = '0;
        end
        HB_BURST: if (cnt_q == LEN_LAST) begin
          st_d  = HB_IDLE;
          cnt_d = '0;
        end
        default: cnt_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= HB_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign burst_o = (st_q == HB_BURST);

  assert_hb_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !burst_o);
  assert_hb_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && end_i) |=> (st_q == HB_WAIT));
endmodule

// File: rtl/coll_ind_ctrl.sv
module coll_ind_ctrl #(
  parameter int DIV_RATIO   = 10,
  parameter int JAB_TICKS   = 2_000_000,
  parameter int UNJAB_TICKS = 50_000_000,
  parameter int HB_DLY      = 100,
  parameter int HB_LEN      = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic coll_thresh_i,
  input  logic tx_active_i,
  input  logic tx_end_i,
  input  logic hb_en_i,
  output logic coll_p_o,
  output logic coll_n_o,
  output logic tx_disable_o
);
  logic jab_lock, hb_burst, src_any, tone_hi;
  logic p_q, n_q, p_d, n_d;

  jab_guard #(.JAB_TICKS(JAB_TICKS), .UNJAB_TICKS(UNJAB_TICKS)) u_jab (
    .clk(clk), .rst_n(rst_n), .tx_act_i(tx_active_i), .lock_o(jab_lock));

  hb_timer #(.HB_DLY(HB_DLY), .HB_LEN(HB_LEN)) u_hb (
    .clk(clk), .rst_n(rst_n), .en_i(hb_en_i), .end_i(tx_end_i),
    .burst_o(hb_burst));

  assign src_any = coll_thresh_i | jab_lock | hb_burst;

  tone_div #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk(clk), .rst_n(rst_n), .run_i(src_any), .tone_hi_o(tone_hi));

  always_comb begin
    p_d = src_any &  tone_hi;
    n_d = src_any & ~tone_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_q <= 1'b0;
      n_q <= 1'b0;
    end else begin
      p_q <= p_d;
      n_q <= n_d;
    end
  end

  assign coll_p_o     = p_q;
  assign coll_n_o     = n_q;
  assign tx_disable_o = jab_lock;

  assert_coll_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
    coll_thresh_i |=> (coll_p_o || coll_n_o));
  assert_lock_drives_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_disable_o |=> (coll_p_o || coll_n_o));
  assert_legs_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(coll_p_o && coll_n_o));
  assert_idle_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!coll_thresh_i && !tx_disable_o && !hb_burst) |=> (!coll_p_o && !coll_n_o));
endmodule

// File: tb/coll_ind_ctrl_tb.sv
module coll_ind_ctrl_tb;
  localparam int DIV = 10;
  localparam int JAB = 40;
  localparam int UNJ = 60;
  localparam int DLY = 12;
  localparam int LEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic coll = 1'b0, txa = 1'b0, txe = 1'b0, hben = 1'b0;
  logic cp, cn, txd;
  int total = 0, bad = 0, cycles = 0;

  always #4 clk = ~clk;

  coll_ind_ctrl #(.DIV_RATIO(DIV), .JAB_TICKS(JAB), .UNJAB_TICKS(UNJ),
    .HB_DLY(DLY), .HB_LEN(LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .coll_thresh_i(coll), .tx_active_i(txa),
    .tx_end_i(txe), .hb_en_i(hben), .coll_p_o(cp), .coll_n_o(cn),
    .tx_disable_o(txd));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    step(1);
    chk(!cp && !cn && !txd, "R10 reset outputs", {cp, cn, txd}, 0);
    rst_n = 1'b1;
    step(3);
    chk(!cp && !cn, "R9 idle zero differential", {cp, cn}, 0);
  endtask

  task automatic t_collision();
    int ph = 0, nh = 0, both = 0;
    coll = 1'b1;
    step(1);
    chk(cp && !cn, "R1 collision starts on p leg", {cp, cn}, 2);
    for (int i = 1; i < 20; i++) begin
      if (i == 5) chk(cp, "R9 p high through 5th cycle", cp, 1);
      if (cp) ph++;
      if (cn) nh++;
      if (cp && cn) both++;
      step(1);
      if (i == 5) chk(cn && !cp, "R9 n leg after half period", {cp, cn}, 1);
    end
    if (cp) ph++;
    if (cn) nh++;
    chk(ph == 10, "R9 p high cycles in two periods", ph, 10);
    chk(nh == 10, "R9 n high cycles in two periods", nh, 10);
    chk(both == 0, "R9 legs never both high", both, 0);
    coll = 1'b0;
    step(1);
    chk(!cp && !cn, "R1 collision removed -> idle", {cp, cn}, 0);
  endtask

  task automatic t_jab_short();
    txa = 1'b1; step(JAB - 1);
    txa = 1'b0; step(1);
    txa = 1'b1; step(JAB - 1);
    chk(!txd, "R2 broken run does not lock", txd, 0);
    txa = 1'b0; step(2);
    chk(!cp && !cn, "R2 no indicator without lock", {cp, cn}, 0);
  endtask

  task automatic t_jab_lock();
    txa = 1'b1;
    step(JAB - 1);
    chk(!txd, "R2 not locked one cycle early", txd, 0);
    step(1);
    chk(txd, "R2 locked after JAB_TICKS", txd, 1);
    chk(!cp && !cn, "R3 indicator lags lock one cycle", {cp, cn}, 0);
    step(1);
    chk(cp, "R3 lock drives indicator", cp, 1);
    txa = 1'b0;
    step(UNJ - 1);
    chk(txd, "R4 still locked one cycle before unjab", txd, 1);
    step(1);
    chk(!txd, "R4 unlocked after UNJAB_TICKS", txd, 0);
    step(1);
    chk(!cp && !cn, "R4 indicator removed after unjab", {cp, cn}, 0);
    txa = 1'b1;
    step(JAB - 1);
    chk(!txd, "R4 activity timer reset by unjab", txd, 0);
    step(1);
    chk(txd, "R4 relock after fresh run", txd, 1);
    txa = 1'b0; step(30);
    txa = 1'b1; step(1);
    txa = 1'b0;
    step(UNJ - 1);
    chk(txd, "R5 unjab restarted by activity", txd, 1);
    step(1);
    chk(!txd, "R5 unlock after full quiet period", txd, 0);
    step(2);
  endtask

  task automatic pulse_end();
    txe = 1'b1; step(1); txe = 1'b0;
  endtask

  task automatic measure_burst(input string tag);
    int cnt = 0;
    step(DLY);
    chk(!cp && !cn, {tag, " idle before delay ends"}, {cp, cn}, 0);
    for (int i = 0; i < LEN + 6; i++) begin
      step(1);
      if (cp || cn) cnt++;
      if (i == 0) chk(cp, {tag, " burst starts at HB_DLY+1"}, cp, 1);
    end
    chk(cnt == LEN, {tag, " burst length"}, cnt, LEN);
  endtask

  task automatic t_heartbeat();
    hben = 1'b1;
    step(2);
    pulse_end();
    measure_burst("R6");
    pulse_end();
    step(5);
    pulse_end();
    measure_burst("R7");
  endtask

  task automatic t_hb_off();
    int act = 0;
    hben = 1'b0;
    step(1);
    pulse_end();
    for (int i = 0; i < DLY + LEN + 5; i++) begin
      step(1);
      if (cp || cn) act++;
    end
    chk(act == 0, "R8 no burst when disabled", act, 0);
    hben = 1'b1;
    step(1);
    pulse_end();
    step(4);
    hben = 1'b0;
    act = 0;
    for (int i = 0; i < DLY + LEN + 5; i++) begin
      step(1);
      if (cp || cn) act++;
    end
    chk(act == 0, "R8 disable cancels pending burst", act, 0);
  endtask

  initial begin
    t_reset();
    t_collision();
    t_jab_short();
    t_jab_lock();
    t_heartbeat();
    t_hb_off();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule